// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. The processor side hands it stores made of a word address and one data word. A store is complete for the processor once the buffer accepts it. The buffer keeps up to `DEPTH` block-sized entries and drains them, oldest first, through a valid/ready port. Each drain carries a block address, every word slot of the block and a per-word mask that shows which words hold data.

A store to a block that is already held in a non-I/O entry updates that entry in place and does not take a new slot, so several single-word stores become one multiword memory write. Stores that fall in the I/O window always take an entry of their own.

Read misses from the cache pass through the buffer on their way to memory. Each read is compared against all held entries at once. A read that hits no entry goes to memory immediately, ahead of the queued writes. A read that hits an entry is held back while the queue drains in order, and it is released once no held entry covers its block. The read therefore never sees stale memory contents.

Top module: `wrbuf_bypass`

## Requirements
- R1: After reset the buffer is empty: `stReady` is 1, `drValid` is 0 and `memRdValid` is 0.
- R2: The word address is split as block = `addr[ADDR_W-1:OFF_W]` and word = `addr[OFF_W-1:0]` (OFF_W = log2 WORDS, which is 2 by default). Entries drain in acceptance order. Word i of `drData` is `drData[i*DATA_W +: DATA_W]`, and it is valid when `drMask[i]` is 1.
- R3: When all `DEPTH` entries are occupied and the store cannot merge, `stReady` is 0 until an entry drains.
- R4: A store whose block matches a held non-I/O entry merges into that entry. It sets the mask bit of its word, and the newer data replaces any older data for that word. A merging store is accepted even when the buffer is full.
- R5: A block whose bits under `IO_MASK` equal `IO_MATCH` is I/O. With the defaults these are word addresses 0xC0 to 0xFF. An I/O store never merges and always takes a new entry.
- R6: A store that matches the oldest entry in the same cycle that this entry drains takes a new entry instead of merging.
- R7: A read that matches no held entry appears on `memRdValid` in the same cycle. While it is pending, `drValid` is 0.
- R8: A read that matches a held entry is held with `memRdValid` at 0, and stores stall. Entries drain in order up to and including the last matching one, and then the read is released.
- R9: Memory updated only by the drain port holds the value of the last store to every word. Every read sees the data of all stores accepted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | Store request |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Store accepted this cycle (0 = processor stall) |
| rdValid | input | 1 | Read-miss request |
| rdAddr | input | ADDR_W | Read word address |
| rdReady | output | 1 | Read forwarded to memory this cycle |
| memRdValid | output | 1 | Read request to memory |
| memRdAddr | output | ADDR_W | Read address to memory |
| memRdReady | input | 1 | Memory accepts the read |
| drValid | output | 1 | Drain entry available |
| drReady | input | 1 | Memory accepts the drain entry |
| drAddr | output | ADDR_W-OFF_W | Block address of the draining entry |
| drData | output | WORDS*DATA_W | Block data, word i in slice i |
| drMask | output | WORDS | Per-word valid mask |

## Verification
The directed patterns cover several separate cases. Repeated stores to one block tell merging apart from allocation. Four distinct blocks followed by a fifth tell the full stall apart from acceptance. A store to a full buffer that hits a held block shows that merging bypasses the stall. Back-to-back I/O stores to one block must give two drains. A store to the head while the head drains must survive as a separate entry. A read outside every held block shows the bypass, and a read into the second queued block shows the in-order drain before it is released. A random mix of stores and reads over a narrow address range then produces many merges, conflicts and I/O accesses under a randomly stalling drain. Each read and the final memory image are compared with a sequential memory model.

// File: rtl/wrbuf_pkg.sv
`timescale 1ns/1ps
package wrbuf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;  // write store into a fresh entry at the tail
    logic merge;  // fold store into an existing entry
    logic pop;    // head entry leaves through the drain port
  } wbStrobe_t;
endpackage

// File: rtl/wrbuf_dpath.sv
`timescale 1ns/1ps
module wrbuf_dpath
  import wrbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned IO_MASK  = 'h30,
  parameter int unsigned IO_MATCH = 'h30,
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned BLK_W   = ADDR_W - OFF_W,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wbStrobe_t               stb,
  input  logic [IDX_W-1:0]        allocIdx,
  input  logic [IDX_W-1:0]        mergeIdx,
  input  logic [IDX_W-1:0]        headIdx,
  input  logic [DEPTH-1:0]        validVec,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [DATA_W-1:0]       stData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DEPTH-1:0]        stMatchVec,
  output logic [DEPTH-1:0]        rdMatchVec,
  output logic                    stIsIo,
  output logic [BLK_W-1:0]        drBlk,
  output logic [WORDS*DATA_W-1:0] drData,
  output logic [WORDS-1:0]        drMask
);
  logic [BLK_W-1:0]                  entBlk  [DEPTH];
  logic [WORDS-1:0][DATA_W-1:0]      entData [DEPTH];
  logic [WORDS-1:0]                  entMask [DEPTH];
  logic                              entIo   [DEPTH];

  logic [BLK_W-1:0] stBlk, rdBlk;
  logic [OFF_W-1:0] stOff;
  logic [WORDS-1:0] wordSel;

  assign stBlk   = stAddr[ADDR_W-1:OFF_W];
  assign stOff   = stAddr[OFF_W-1:0];
  assign rdBlk   = rdAddr[ADDR_W-1:OFF_W];
  assign stIsIo  = (stBlk & BLK_W'(IO_MASK)) == BLK_W'(IO_MATCH);
  assign wordSel = WORDS'(1) << stOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        entBlk[i]  <= '0;
        entData[i] <= '0;
        entMask[i] <= '0;
        entIo[i]   <= 1'b0;
      end
    end else begin
      if (stb.alloc) begin
        entBlk[allocIdx]         <= stBlk;
        entIo[allocIdx]          <= stIsIo;
        entMask[allocIdx]        <= wordSel;
        entData[allocIdx][stOff] <= stData;
      end
      if (stb.merge) begin
        entMask[mergeIdx]        <= entMask[mergeIdx] | wordSel;
        entData[mergeIdx][stOff] <= stData;
      end
    end
  end

  // Associative compare against every held entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign stMatchVec[g] = validVec[g] && !entIo[g] && (entBlk[g] == stBlk);
    assign rdMatchVec[g] = validVec[g] && (entBlk[g] == rdBlk);
  end

  assign drBlk  = entBlk[headIdx];
  assign drData = entData[headIdx];
  assign drMask = entMask[headIdx];

  // R2/R4: a live head entry always carries at least one written word
  a_r4_head_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    validVec[headIdx] |-> (drMask != '0));

  // R5: I/O entries are never merge targets
  a_r5_io_never_merged: assert property (@(posedge clk) disable iff (!rst_n)
    stb.merge |-> !entIo[mergeIdx]);
endmodule

// File: rtl/wrbuf_ctrl.sv
`timescale 1ns/1ps
module wrbuf_ctrl
  import wrbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stValid,
  input  logic             stIsIo,
  input  logic [DEPTH-1:0] stMatchVec,
  input  logic             rdValid,
  input  logic [DEPTH-1:0] rdMatchVec,
  input  logic             drReady,
  input  logic             memRdReady,
  output wbStrobe_t        stb,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] mergeIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [DEPTH-1:0] validVec,
  output logic             stReady,
  output logic             drValid,
  output logic             memRdValid,
  output logic             rdReady
);
  logic [IDX_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] count;
  logic             rdConflict, bypassRd, holdRd;
  logic             drFire, stFire, canMerge, full;
  logic [DEPTH-1:0] headMask, mergeVec;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdConflict = |rdMatchVec;
  assign bypassRd   = rdValid && !rdConflict;
  assign holdRd     = rdValid && rdConflict;
  assign full       = (count == CNT_W'(DEPTH));

  // Drain yields to a bypassing read
  assign drValid = (count != '0) && !bypassRd;
  assign drFire  = drValid && drReady;

  always_comb begin
    headMask = '0;
    if (drFire) headMask[headPtr] = 1'b1;
  end

  assign mergeVec = stMatchVec & ~headMask;
  assign canMerge = (|mergeVec) && !stIsIo;

  always_comb begin
    mergeIdx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (mergeVec[i]) mergeIdx = IDX_W'(i);
  end

  assign stReady   = !holdRd && (canMerge || !full);
  assign stFire    = stValid && stReady;
  assign stb.alloc = stFire && !canMerge;
  assign stb.merge = stFire && canMerge;
  assign stb.pop   = drFire;
  assign allocIdx  = tailPtr;
  assign headIdx   = headPtr;

  assign memRdValid = bypassRd;
  assign rdReady    = bypassRd && memRdReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      count    <= '0;
      validVec <= '0;
    end else begin
      if (stb.alloc) tailPtr <= nextPtr(tailPtr);
      if (stb.pop)   headPtr <= nextPtr(headPtr);
      count <= count + CNT_W'(stb.alloc) - CNT_W'(stb.pop);
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.alloc && (tailPtr == IDX_W'(i)))     validVec[i] <= 1'b1;
        else if (stb.pop && (headPtr == IDX_W'(i)))  validVec[i] <= 1'b0;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !drFire) |=> full);

  a_r2_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(validVec) == int'(count));

  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mergeVec));

  a_r6_head_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.merge && stb.pop) |-> (mergeIdx != headPtr));

  a_r8_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
    holdRd |-> drValid);
endmodule

// File: rtl/wrbuf_bypass.sv
`timescale 1ns/1ps
module wrbuf_bypass
  import wrbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned IO_MASK  = 'h30,
  parameter int unsigned IO_MATCH = 'h30,
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned BLK_W   = ADDR_W - OFF_W,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stValid,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [DATA_W-1:0]       stData,
  output logic                    stReady,
  input  logic                    rdValid,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    rdReady,
  output logic                    memRdValid,
  output logic [ADDR_W-1:0]       memRdAddr,
  input  logic                    memRdReady,
  output logic                    drValid,
  input  logic                    drReady,
  output logic [BLK_W-1:0]        drAddr,
  output logic [WORDS*DATA_W-1:0] drData,
  output logic [WORDS-1:0]        drMask
);
  wbStrobe_t        stb;
  logic [IDX_W-1:0] allocIdx, mergeIdx, headIdx;
  logic [DEPTH-1:0] validVec, stMatchVec, rdMatchVec;
  logic             stIsIo;

  assign memRdAddr = rdAddr;

  wrbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .stValid(stValid), .stIsIo(stIsIo), .stMatchVec(stMatchVec),
    .rdValid(rdValid), .rdMatchVec(rdMatchVec),
    .drReady(drReady), .memRdReady(memRdReady),
    .stb(stb), .allocIdx(allocIdx), .mergeIdx(mergeIdx), .headIdx(headIdx),
    .validVec(validVec), .stReady(stReady), .drValid(drValid),
    .memRdValid(memRdValid), .rdReady(rdReady)
  );

  wrbuf_dpath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS),
    .IO_MASK(IO_MASK), .IO_MATCH(IO_MATCH)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .allocIdx(allocIdx), .mergeIdx(mergeIdx), .headIdx(headIdx),
    .validVec(validVec), .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr),
    .stMatchVec(stMatchVec), .rdMatchVec(rdMatchVec), .stIsIo(stIsIo),
    .drBlk(drAddr), .drData(drData), .drMask(drMask)
  );
endmodule

// File: tb/wrbuf_bypass_tb.sv
`timescale 1ns/1ps
module wrbuf_bypass_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stValid = 1'b0;
  logic [7:0]   stAddr = '0;
  logic [31:0]  stData = '0;
  logic         stReady;
  logic         rdValid = 1'b0;
  logic [7:0]   rdAddr = '0;
  logic         rdReady;
  logic         memRdValid;
  logic [7:0]   memRdAddr;
  logic         memRdReady = 1'b1;
  logic         drValid;
  logic         drReady;
  logic [5:0]   drAddr;
  logic [127:0] drData;
  logic [3:0]   drMask;

  logic drReadyDir = 1'b0;
  logic drRandBit  = 1'b0;
  logic randDrain  = 1'b0;
  assign drReady = randDrain ? drRandBit : drReadyDir;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] mem    [256];
  logic [31:0] refMem [256];
  logic [31:0] rdExpQ [$];

  always #2 clk = ~clk;

  wrbuf_bypass dut_i (
    .clk(clk), .rst_n(rst_n),
    .stValid(stValid), .stAddr(stAddr), .stData(stData), .stReady(stReady),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .memRdValid(memRdValid), .memRdAddr(memRdAddr), .memRdReady(memRdReady),
    .drValid(drValid), .drReady(drReady), .drAddr(drAddr),
    .drData(drData), .drMask(drMask)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Memory model and read monitor (scoreboard pop side)
  always @(posedge clk) begin
    if (rst_n && rdValid && rdReady) begin
      if (rdExpQ.size() == 0) chk(0, "R9 unexpected read", {120'd0, rdAddr}, 0);
      else begin
        logic [31:0] e;
        e = rdExpQ.pop_front();
        chk(mem[rdAddr] == e, "R9 read data", mem[rdAddr], e);
      end
    end
    if (rst_n && drValid && drReady)
      for (int w = 0; w < 4; w++)
        if (drMask[w]) mem[{drAddr, w[1:0]}] <= drData[w*32 +: 32];
  end

  always @(negedge clk) drRandBit <= 1'($urandom % 2);

  task automatic doStore(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    @(posedge clk);
    refMem[a] = d;
    #1 stValid = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a);
    @(negedge clk);
    rdExpQ.push_back(refMem[a]);
    rdValid = 1'b1; rdAddr = a;
    #1;
    while (!rdReady) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 rdValid = 1'b0;
  endtask

  task automatic drainOne(input logic [5:0] blk, input logic [3:0] msk, input string tag);
    @(negedge clk); #1;
    chk(drValid == 1'b1, {tag, " drValid"}, drValid, 1);
    chk(drAddr == blk, {tag, " drAddr"}, drAddr, blk);
    chk(drMask == msk, {tag, " drMask"}, drMask, msk);
    drReadyDir = 1'b1;
    @(posedge clk); #1 drReadyDir = 1'b0;
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk(stReady == 1'b1, "R1 stReady", stReady, 1);
    chk(drValid == 1'b0, "R1 drValid", drValid, 0);
    chk(memRdValid == 1'b0, "R1 memRdValid", memRdValid, 0);

    // R4 merge with overwrite of the same word
    doStore(8'h10, 32'hA0A0_0001);
    doStore(8'h11, 32'hB0B0_0002);
    doStore(8'h11, 32'hC0C0_0003);
    @(negedge clk); #1;
    chk(drData[31:0] == 32'hA0A0_0001, "R4 word0", drData[31:0], 32'hA0A0_0001);
    chk(drData[63:32] == 32'hC0C0_0003, "R4 word1 overwrite", drData[63:32], 32'hC0C0_0003);
    drainOne(6'h04, 4'b0011, "R4 merged entry");
    @(negedge clk); #1;
    chk(drValid == 1'b0, "R4 single entry", drValid, 0);

    // R3 full stall, R4 merge accepted while full, R2 order
    doStore(8'h04, 32'h11);
    doStore(8'h08, 32'h22);
    doStore(8'h0C, 32'h33);
    doStore(8'h14, 32'h44);
    @(negedge clk);
    stValid = 1'b1; stAddr = 8'h18; stData = 32'h55;
    #1 chk(stReady == 1'b0, "R3 full stall", stReady, 0);
    stValid = 1'b0;
    @(negedge clk);
    stValid = 1'b1; stAddr = 8'h09; stData = 32'h66;
    #1 chk(stReady == 1'b1, "R4 merge while full", stReady, 1);
    @(posedge clk); refMem[8'h09] = 32'h66; #1 stValid = 1'b0;
    drainOne(6'h01, 4'b0001, "R2 order 1");
    drainOne(6'h02, 4'b0011, "R2 order 2");
    drainOne(6'h03, 4'b0001, "R2 order 3");
    drainOne(6'h05, 4'b0001, "R2 order 4");

    // R5 I/O region never merges
    doStore(8'hC0, 32'h77);
    doStore(8'hC1, 32'h88);
    drainOne(6'h30, 4'b0001, "R5 io first");
    drainOne(6'h30, 4'b0010, "R5 io second");

    // R6 store to head while it drains
    doStore(8'h20, 32'h99);
    @(negedge clk);
    drReadyDir = 1'b1;
    stValid = 1'b1; stAddr = 8'h21; stData = 32'hAA;
    #1;
    chk(stReady == 1'b1, "R6 accepted", stReady, 1);
    chk(drMask == 4'b0001, "R6 head mask", drMask, 4'b0001);
    @(posedge clk); refMem[8'h21] = 32'hAA; #1;
    stValid = 1'b0; drReadyDir = 1'b0;
    @(negedge clk); #1;
    chk(drData[63:32] == 32'hAA, "R6 new entry data", drData[63:32], 32'hAA);
    drainOne(6'h08, 4'b0010, "R6 new entry");

    // R7 read bypass
    doStore(8'h24, 32'hBB);
    @(negedge clk);
    rdExpQ.push_back(refMem[8'h40]);
    rdValid = 1'b1; rdAddr = 8'h40;
    #1;
    chk(memRdValid == 1'b1, "R7 forwarded", memRdValid, 1);
    chk(memRdAddr == 8'h40, "R7 address", memRdAddr, 8'h40);
    chk(drValid == 1'b0, "R7 drain held", drValid, 0);
    @(posedge clk); #1 rdValid = 1'b0;

    // R8 conflicting read waits for in-order drain
    doStore(8'h29, 32'hCC);
    doStore(8'h2C, 32'hDD);
    @(negedge clk);
    rdExpQ.push_back(refMem[8'h29]);
    rdValid = 1'b1; rdAddr = 8'h29;
    stValid = 1'b1; stAddr = 8'h30; stData = 32'hEE;
    #1;
    chk(memRdValid == 1'b0, "R8 held", memRdValid, 0);
    chk(stReady == 1'b0, "R8 store stall", stReady, 0);
    chk(drAddr == 6'h09, "R8 drain head", drAddr, 6'h09);
    stValid = 1'b0;
    drReadyDir = 1'b1;
    @(negedge clk); #1;
    chk(memRdValid == 1'b0, "R8 still held", memRdValid, 0);
    chk(drAddr == 6'h0A, "R8 matching entry", drAddr, 6'h0A);
    @(negedge clk); #1;
    chk(memRdValid == 1'b1, "R8 released", memRdValid, 1);
    chk(drValid == 1'b0, "R7 drain yields", drValid, 0);
    @(posedge clk); #1 rdValid = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(drValid == 1'b0, "R8 queue empty", drValid, 0);
    drReadyDir = 1'b0;

    // R9 random mix against sequential model
    randDrain = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      a = ($urandom % 5 == 0) ? 8'(8'hC0 + $urandom % 16) : 8'($urandom % 48);
      if ($urandom % 3 == 0) doRead(a);
      else doStore(a, $urandom);
    end
    randDrain = 1'b0;
    drReadyDir = 1'b1;
    repeat (20) @(negedge clk);
    #1 chk(drValid == 1'b0, "R9 drained", drValid, 0);
    chk(rdExpQ.size() == 0, "R9 reads served", rdExpQ.size(), 0);
    for (int i = 0; i < 256; i++)
      chk(mem[i] == refMem[i], "R9 memory image", mem[i], refMem[i]);

    done = 1;
    finish();
  end
endmodule